// File: doc/BRIEF.md
# Obfuscated Linear Scan Chain

This block is a K-stage scan register meant to stand in for a plain scan shift chain. Every stage is a flip-flop with a 2:1 selector in front of it. With scan enable low, each stage loads its bit from the parallel capture bus driven by the surrounding logic. With scan enable high, each stage takes the bit of its predecessor (the serial input for the first stage). That bit may be inverted, and it may be XORed with the serial input or with stages further up the chain. The serial output is the last stage, optionally XORed with earlier stages and a constant.

All inversion and XOR positions are fixed at elaboration by parameters, and no later stage feeds back into an earlier one. In scan mode the chain therefore behaves as a K-cycle delay line up to a known linear pattern. A tester that knows the pattern can load any state in K shifts and recover any captured state from K output bits. A party that sees only the pins cannot tell the true bit-to-flip-flop mapping.

A package function expands the parameters symbolically into the affine form of the output K cycles ahead. Elaboration rejects illegal tap layouts and any structure whose output still depends on the old state after K shifts.

Top module: `obf_scan_chain`

## Requirements
- R1: A high synchronous reset clears every stage to 0 at the next rising edge, whatever scan enable and the other inputs are doing.
- R2: With scan enable low, `state_q` equals the value `par_in` had before the preceding rising edge.
- R3: With scan enable high, stage i loads: its predecessor (stage i-1), or `scan_in` for stage 0; XOR `INV_MASK[i]`; XOR (`X_TAPS[i]` AND `scan_in`); XOR every stage j for which bit i*K+j of `STAGE_TAPS` is set. Such a bit is legal only for j < i-1. `X_TAPS[0]` must be 0. Bit 0 of `state_q` is the stage nearest `scan_in`.
- R4: `scan_out` = stage K-1 XOR `OUT_INV` XOR every stage j with `OUT_TAPS[j]` set (j < K-1). After K consecutive scan cycles, z(t+K) = x(t) ^ c0 ^ c1·x(t+1) ^ … ^ cK·x(t+K), where x is `scan_in`, z is `scan_out`, and each ci is a constant fixed by the parameters.
- R5: Configuration A (K=3, INV_MASK=3'b010, X_TAPS=3'b100, no stage taps, OUT_TAPS=3'b001, OUT_INV=1) is a pure delay: z(t+3) = x(t).
- R6: Configuration B (the defaults: K=3, INV_MASK=3'b010, X_TAPS=3'b100, no taps of any kind, OUT_INV=0) gives z(t+3) = x(t) ^ 1 ^ x(t+2), i.e. coefficients c0..c3 = 1,0,1,0.
- R7: In both configurations, shifting in 1^a^c, then 1^b, then a leaves (state_q[0], state_q[1], state_q[2]) = (a, b, c) regardless of the starting state.
- R8: In configuration A, from a state (y1,y2,y3) = (state_q[0],[1],[2]), the next three `scan_out` values under scan are ~(y1^y3), ~y2, y1, for any `scan_in` bits.
- R9: In configuration B, from state (y1,y2,y3) with `scan_in` bits x0 and x1 shifted in, the next three `scan_out` values are y3, x0^y2, x1^1^y1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| scan_en | input | 1 | High selects the chain path, low selects parallel capture |
| scan_in | input | 1 | Serial test input |
| par_in | input | K | Parallel capture values from the surrounding logic |
| scan_out | output | 1 | Serial test output (combinational from the stages) |
| state_q | output | K | Stage contents, bit 0 nearest the serial input |

## Verification
A capture or a shift shows up on `state_q` after exactly one rising edge. `scan_out` is a combinational function of the stages, so it reflects a new state in the same cycle that state appears. The delay relation is therefore due on the sample taken after the K-th scan edge that follows a given input bit. The bench drives inputs at the falling edge and reads results at the next falling edge, so each read sees exactly one more rising edge. For the delay relation it keeps its own history of driven bits and starts comparing only once K scan edges have passed since scan enable was raised. In the justification and observation checks, the output bits are read one per shift, starting at the sample right after the capture.

// File: rtl/obf_scan_pkg.sv
package obf_scan_pkg;

   localparam int MAX_STAGES = 16;
   localparam int FORM_W     = 64;

   typedef logic [FORM_W-1:0] affine_t;

   // Affine form of the serial output K scan cycles after time t.
   // bit 0           : constant 1
   // bit 1+s         : x(t+s), s = 0..k
   // bit k+2+j       : initial content of stage j
   function automatic affine_t output_form(
      input int                  k,
      input logic [15:0]         inv,
      input logic [15:0]         xt,
      input logic [255:0]        st,
      input logic [15:0]         ot,
      input logic                oinv
   );
      affine_t cur [MAX_STAGES];
      affine_t nxt [MAX_STAGES];
      affine_t one;
      affine_t xv;
      affine_t z;
      one = affine_t'(1);
      for (int j = 0; j < MAX_STAGES; j++) begin
         cur[j] = (j < k) ? (one << (k + 2 + j)) : '0;
         nxt[j] = '0;
      end
      for (int s = 0; s < MAX_STAGES; s++) begin
         if (s < k) begin
            xv = one << (1 + s);
            for (int i = 0; i < MAX_STAGES; i++) begin
               if (i < k) begin
                  nxt[i] = (i == 0) ? xv : cur[(i == 0) ? 0 : i - 1];
                  if (inv[i]) nxt[i] = nxt[i] ^ one;
                  if (xt[i])  nxt[i] = nxt[i] ^ xv;
                  for (int j = 0; j < MAX_STAGES; j++) begin
                     if (j < k && st[i*k + j]) nxt[i] = nxt[i] ^ cur[j];
                  end
               end
            end
            for (int i = 0; i < MAX_STAGES; i++) cur[i] = nxt[i];
         end
      end
      z = cur[k-1];
      if (oinv) z = z ^ one;
      for (int j = 0; j < MAX_STAGES; j++) begin
         if (j < k && ot[j]) z = z ^ cur[j];
      end
      return z;
   endfunction

endpackage

// File: rtl/obf_scan_cell.sv
module obf_scan_cell (
   input  logic clk,
   input  logic rst,
   input  logic scan_en,
   input  logic par_d,
   input  logic chain_d,
   output logic q
);

   logic d_sel;

   always_comb d_sel = scan_en ? chain_d : par_d;

   always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= d_sel;
   end

endmodule

// File: rtl/obf_stage_net.sv
module obf_stage_net #(
   parameter int               K          = 3,
   parameter logic [K-1:0]     INV_MASK   = '0,
   parameter logic [K-1:0]     X_TAPS     = '0,
   parameter logic [K*K-1:0]   STAGE_TAPS = '0
) (
   input  logic          scan_in,
   input  logic [K-1:0]  state_q,
   output logic [K-1:0]  chain_d
);

   if (X_TAPS[0] != 1'b0) begin : g_bad_xtap0
      $error("obf_stage_net: first stage may not tap the serial input");
   end

   for (genvar i = 0; i < K; i++) begin : g_stage
      localparam logic [K-1:0] ROW     = STAGE_TAPS[i*K +: K];
      localparam logic [K-1:0] ALLOWED = (i <= 1) ? '0
                                        : ((K'(1) << (i - 1)) - K'(1));
      logic shift_src;
      logic tap_sum;

      if ((ROW & ~ALLOWED) != '0) begin : g_bad_row
         $error("obf_stage_net: stage tap at or after predecessor");
      end

      if (i == 0) begin : g_head
         assign shift_src = scan_in;
      end else begin : g_body
         assign shift_src = state_q[i-1];
      end

      if (ROW == '0) begin : g_no_taps
         assign tap_sum = 1'b0;
      end else begin : g_taps
         assign tap_sum = ^(state_q & ROW);
      end

      assign chain_d[i] = shift_src ^ INV_MASK[i] ^ (X_TAPS[i] & scan_in) ^ tap_sum;
   end

endmodule

// File: rtl/obf_out_net.sv
module obf_out_net #(
   parameter int            K        = 3,
   parameter logic [K-1:0]  OUT_TAPS = '0,
   parameter logic          OUT_INV  = 1'b0
) (
   input  logic [K-1:0] state_q,
   output logic         scan_out
);

   if (OUT_TAPS[K-1] != 1'b0) begin : g_bad_otap
      $error("obf_out_net: last stage is always in the output, tap bit must be 0");
   end

   if (OUT_TAPS == '0) begin : g_plain
      assign scan_out = state_q[K-1] ^ OUT_INV;
   end else begin : g_mixed
      assign scan_out = state_q[K-1] ^ OUT_INV ^ (^(state_q & OUT_TAPS));
   end

endmodule

// File: rtl/obf_scan_chain.sv
module obf_scan_chain #(
   parameter int               K          = 3,
   parameter logic [K-1:0]     INV_MASK   = 3'b010,
   parameter logic [K-1:0]     X_TAPS     = 3'b100,
   parameter logic [K*K-1:0]   STAGE_TAPS = '0,
   parameter logic [K-1:0]     OUT_TAPS   = '0,
   parameter logic             OUT_INV    = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          scan_en,
   input  logic          scan_in,
   input  logic [K-1:0]  par_in,
   output logic          scan_out,
   output logic [K-1:0]  state_q
);

   localparam obf_scan_pkg::affine_t FORM = obf_scan_pkg::output_form(
      K, 16'(INV_MASK), 16'(X_TAPS), 256'(STAGE_TAPS), 16'(OUT_TAPS), OUT_INV);

   if (K < 1 || K > obf_scan_pkg::MAX_STAGES) begin : g_bad_k
      $error("obf_scan_chain: K out of range");
   end
   if (FORM[1] != 1'b1) begin : g_bad_lead
      $error("obf_scan_chain: oldest input does not reach the output");
   end
   if ((FORM >> (K + 2)) != '0) begin : g_bad_flush
      $error("obf_scan_chain: output still depends on old state after K shifts");
   end

   logic [K-1:0] chain_d;

   obf_stage_net #(
      .K(K), .INV_MASK(INV_MASK), .X_TAPS(X_TAPS), .STAGE_TAPS(STAGE_TAPS)
   ) u_net (
      .scan_in (scan_in),
      .state_q (state_q),
      .chain_d (chain_d)
   );

   for (genvar i = 0; i < K; i++) begin : g_cell
      obf_scan_cell u_cell (
         .clk     (clk),
         .rst     (rst),
         .scan_en (scan_en),
         .par_d   (par_in[i]),
         .chain_d (chain_d[i]),
         .q       (state_q[i])
      );
   end

   obf_out_net #(
      .K(K), .OUT_TAPS(OUT_TAPS), .OUT_INV(OUT_INV)
   ) u_out (
      .state_q  (state_q),
      .scan_out (scan_out)
   );

endmodule

// File: rtl/obf_scan_chain_chk.sv
module obf_scan_chain_chk #(
   parameter int               K          = 3,
   parameter logic [K-1:0]     INV_MASK   = '0,
   parameter logic [K-1:0]     X_TAPS     = '0,
   parameter logic [K*K-1:0]   STAGE_TAPS = '0,
   parameter logic [K-1:0]     OUT_TAPS   = '0,
   parameter logic             OUT_INV    = 1'b0
) (
   input logic          clk,
   input logic          rst,
   input logic          scan_en,
   input logic          scan_in,
   input logic [K-1:0]  par_in,
   input logic          scan_out,
   input logic [K-1:0]  state_q
);

   localparam obf_scan_pkg::affine_t FORM = obf_scan_pkg::output_form(
      K, 16'(INV_MASK), 16'(X_TAPS), 256'(STAGE_TAPS), 16'(OUT_TAPS), OUT_INV);
   localparam int RUNW = $clog2(K + 1) + 1;

   logic [K-1:0]    hist;
   logic [RUNW-1:0] run;
   logic            rst_d;
   logic            exp_z;

   always_ff @(posedge clk) begin
      rst_d   <= rst;
      hist[0] <= scan_in;
      for (int i = 1; i < K; i++) hist[i] <= hist[i-1];
      if (rst || !scan_en)      run <= '0;
      else if (run < RUNW'(K))  run <= run + RUNW'(1);
   end

   always_comb begin
      exp_z = hist[K-1] ^ FORM[0] ^ (FORM[K+1] & scan_in);
      for (int i = 1; i < K; i++) begin
         if (FORM[1+i]) exp_z = exp_z ^ hist[K-1-i];
      end
   end

   // R1
   always @(posedge clk) begin
      if (rst_d) begin
         assert_reset_clear_R1: assert (state_q == '0);
      end
   end

   assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
      !scan_en |=> (state_q == $past(par_in)));

   assert_first_stage_R3: assert property (@(posedge clk) disable iff (rst)
      scan_en |=> (state_q[0] == ($past(scan_in) ^ INV_MASK[0])));

   assert_delay_relation_R4: assert property (@(posedge clk) disable iff (rst)
      (run >= RUNW'(K)) |-> (scan_out == exp_z));

   logic unused_par;
   assign unused_par = ^par_in;

endmodule

bind obf_scan_chain obf_scan_chain_chk #(
   .K(K), .INV_MASK(INV_MASK), .X_TAPS(X_TAPS), .STAGE_TAPS(STAGE_TAPS),
   .OUT_TAPS(OUT_TAPS), .OUT_INV(OUT_INV)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .scan_en  (scan_en),
   .scan_in  (scan_in),
   .par_in   (par_in),
   .scan_out (scan_out),
   .state_q  (state_q)
);

// File: tb/tb_obf_scan_chain.sv
`timescale 1ns/1ps
module tb_obf_scan_chain;

   logic       clk = 1'b0;
   logic       rst;
   logic       scan_en;
   logic       scan_in;
   logic [2:0] par_in;
   logic [2:0] q_a, q_b;
   logic       z_a, z_b;
   int         n_cmp = 0;
   int         n_bad = 0;
   bit         done  = 1'b0;

   always #5 clk = ~clk;

   // configuration B (defaults)
   obf_scan_chain dut (
      .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in),
      .par_in(par_in), .scan_out(z_b), .state_q(q_b));

   // configuration A
   obf_scan_chain #(
      .K(3), .INV_MASK(3'b010), .X_TAPS(3'b100), .STAGE_TAPS(9'b0),
      .OUT_TAPS(3'b001), .OUT_INV(1'b1)
   ) dut_a (
      .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in),
      .par_in(par_in), .scan_out(z_a), .state_q(q_a));

   task automatic chk3(input string req, input logic [2:0] act, input logic [2:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic chk1(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic cyc(input logic x, input logic s, input logic [2:0] p);
      scan_in = x; scan_en = s; par_in = p;
      @(negedge clk);
   endtask

   task automatic t_reset;
      rst = 1'b1;
      cyc(1'b1, 1'b1, 3'b111);
      cyc(1'b1, 1'b1, 3'b111);
      chk3("R1 reset A", q_a, 3'b000);
      chk3("R1 reset B", q_b, 3'b000);
      rst = 1'b0;
      cyc(1'b0, 1'b0, 3'b101);
      rst = 1'b1;
      cyc(1'b0, 1'b0, 3'b111);
      chk3("R1 reset beats capture", q_a, 3'b000);
      cyc(1'b1, 1'b1, 3'b000);
      chk3("R1 reset beats shift", q_b, 3'b000);
      rst = 1'b0;
   endtask

   task automatic t_capture;
      logic [2:0] pats [4];
      pats = '{3'b101, 3'b010, 3'b111, 3'b001};
      foreach (pats[n]) begin
         cyc(1'b1, 1'b0, pats[n]);
         chk3("R2 capture A", q_a, pats[n]);
         chk3("R2 capture B", q_b, pats[n]);
      end
   endtask

   task automatic t_shift_rule;
      logic [2:0] m;
      logic [4:0] xs;
      xs = 5'b01101;
      cyc(1'b0, 1'b0, 3'b000);
      m = 3'b000;
      for (int n = 0; n < 5; n++) begin
         cyc(xs[n], 1'b1, 3'b111);
         m = {xs[n] ^ m[1], ~m[0], xs[n]};
         chk3("R3 stage rule A", q_a, m);
         chk3("R3 stage rule B", q_b, m);
      end
   endtask

   task automatic t_delay;
      logic [15:0] xs;
      xs = 16'hB4E3;
      cyc(1'b0, 1'b0, 3'b110);
      for (int n = 0; n < 16; n++) begin
         cyc(xs[n], 1'b1, 3'b000);
         if (n >= 2) begin
            chk1("R4/R5 pure delay A", z_a, xs[n-2]);
            chk1("R4/R6 coefficients B", z_b, xs[n-2] ^ 1'b1 ^ xs[n]);
         end
      end
   endtask

   task automatic t_justify;
      for (int v = 0; v < 8; v++) begin
         logic [2:0] tg;
         tg = 3'(v);
         cyc(1'b0, 1'b0, ~tg);
         cyc(1'b1 ^ tg[0] ^ tg[2], 1'b1, 3'b000);
         cyc(1'b1 ^ tg[1], 1'b1, 3'b000);
         cyc(tg[0], 1'b1, 3'b000);
         chk3("R7 load A", q_a, tg);
         chk3("R7 load B", q_b, tg);
      end
   endtask

   task automatic t_observe;
      for (int v = 0; v < 8; v++) begin
         logic [2:0] y;
         logic       x0, x1;
         y  = 3'(v);
         x0 = ^y;
         x1 = y[1];
         cyc(1'b0, 1'b0, y);
         chk1("R8 observe A z0", z_a, ~(y[0] ^ y[2]));
         chk1("R9 observe B z0", z_b, y[2]);
         cyc(x0, 1'b1, 3'b000);
         chk1("R8 observe A z1", z_a, ~y[1]);
         chk1("R9 observe B z1", z_b, x0 ^ y[1]);
         cyc(x1, 1'b1, 3'b000);
         chk1("R8 observe A z2", z_a, y[0]);
         chk1("R9 observe B z2", z_b, x1 ^ 1'b1 ^ y[0]);
      end
   endtask

   initial begin
      rst = 1'b1; scan_en = 1'b1; scan_in = 1'b0; par_in = 3'b111;
      @(negedge clk);
      t_reset();
      t_capture();
      t_shift_rule();
      t_delay();
      t_justify();
      t_observe();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule